// File: doc/BRIEF.md
# Cache-Line Zeroing Engine

This block carries out a single "zero the data-cache block" operation for a load/store pipeline. A command holds an effective address, a line-size selector, a compatibility enable, a two-bit compatibility mode field and the instruction opcode. The engine takes one command at a time over a valid/ready handshake. It works out how many bytes to clear and rounds the address down to that boundary. It then fills the block with zeros through a 64-bit store port, one doubleword per accepted store beat.

The load-reservation address is held outside the block and is an input here. In the cycle after a command is accepted, the engine compares the reservation address against the line, using the same mask it applied to the command address. On a match it raises a kill strobe, and the owner of the reservation sets it to all ones. Stores start only after this check. After the final beat, a one-cycle done strobe marks the end of the operation.

The command interface is valid/ready. `start_ready` is high only while the engine is idle. A command is taken on a clock edge where `start_valid` and `start_ready` are both high, and `start_valid` has no effect at any other time. The store port is also valid/ready. Once `st_valid` rises, it and `st_addr` stay stable until an edge where `st_ready` is high. The engine does not advance while `st_ready` stays low, so the memory side can stall it for any number of cycles.

Top module: `line_zero_engine`

## Requirements
- R1: The selector `line_sel` picks the zeroing size: 0 gives 32 bytes, 1 gives 64 bytes, and both 2 and 3 give 128 bytes.
- R2: The size is forced to 32 bytes when three conditions hold together: `compat_en` is 1, bit 21 of `opcode` is 0, and `compat_mode` equals 1. In every other case the R1 size applies.
- R3: The base is the start address with its low bits cleared by the mask NOT(size-1). Store beats go to base, base+8, and so on up to base+size-8, in ascending order, and `st_data` is zero on every beat.
- R4: In the cycle after acceptance, `rsv_kill` is high exactly when (`rsv_addr` AND mask) equals the base. It is low in every other cycle. The first store beat is offered in the cycle after that.
- R5: While `st_valid` is high and `st_ready` is low, the next cycle still shows `st_valid` high with the same `st_addr`. The address moves on only after a beat is accepted.
- R6: `done` is high for exactly one cycle, the cycle after the final beat is accepted. `start_ready` is high again in the following cycle.
- R7: `start_ready` is low from the cycle after acceptance until done has been shown, and `start_valid` is ignored during that time. While `start_ready` is high, `st_valid`, `done` and `rsv_kill` are all low.
- R8: While `rst_n` is low, `start_ready` is 1 and `st_valid`, `done` and `rsv_kill` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Engine idle, command can be taken |
| start_addr | input | ADDR_W | Effective address of the command |
| line_sel | input | 2 | Configured line size selector |
| compat_en | input | 1 | Compatibility mode active |
| compat_mode | input | 2 | Compatibility mode field |
| opcode | input | OPC_W | Instruction opcode; bit 21 marks the long form |
| rsv_addr | input | ADDR_W | Current load-reservation address |
| rsv_kill | output | 1 | Reservation must be set to all ones |
| st_valid | output | 1 | Store beat offered |
| st_ready | input | 1 | Store beat accepted |
| st_addr | output | ADDR_W | Doubleword address of the beat |
| st_data | output | DATA_W | Store data, always zero |
| done | output | 1 | Operation finished |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, a 64-bit store port, and line sizes from 32 to 128 bytes with 32 bytes as the compatibility size. Every selector code, including the clamped code 3, can therefore be reached. So can a 128-byte block of sixteen beats and the 32-byte override. The bench also covers each way the override can fail to apply, and reservation addresses that match only at the larger size. A base near the top of the address space shows that the beat address does not carry out of the block.

// File: rtl/lz_pkg.sv
package lz_pkg;
  typedef enum logic [1:0] {
    LZ_IDLE,
    LZ_CHECK,
    LZ_FILL,
    LZ_FINISH
  } lz_phase_e;

  // Opcode bit that marks the long form of the instruction
  localparam int unsigned LZ_OPC_LONG_BIT = 21;
  // Compatibility field value that selects the short block
  localparam logic [1:0] LZ_COMPAT_SHORT = 2'd1;
endpackage

// File: rtl/lz_size_dec.sv
module lz_size_dec #(
  parameter int unsigned MIN_LINE_LOG2    = 5,
  parameter int unsigned MAX_LINE_LOG2    = 7,
  parameter int unsigned COMPAT_LINE_LOG2 = 5,
  parameter int unsigned OPC_W            = 32,
  localparam int unsigned LOG_W = $clog2(MAX_LINE_LOG2 + 1)
) (
  input  logic [1:0]       line_sel,
  input  logic             compat_en,
  input  logic [1:0]       compat_mode,
  input  logic [OPC_W-1:0] opcode,
  output logic [LOG_W-1:0] size_log2
);
  import lz_pkg::*;

  localparam int unsigned SPAN = MAX_LINE_LOG2 - MIN_LINE_LOG2;

  logic force_short;

  always_comb begin
    force_short = compat_en && !opcode[LZ_OPC_LONG_BIT] && (compat_mode == LZ_COMPAT_SHORT);
    if (force_short) begin
      size_log2 = LOG_W'(COMPAT_LINE_LOG2);
    end else if (int'(line_sel) >= int'(SPAN)) begin
      size_log2 = LOG_W'(MAX_LINE_LOG2);
    end else begin
      size_log2 = LOG_W'(MIN_LINE_LOG2) + LOG_W'(line_sel);
    end
  end

  // The decoded size always lies in the supported range (R1)
  always_comb begin
    p_size_range_r1: assert (int'(size_log2) >= int'(MIN_LINE_LOG2) || int'(size_log2) == int'(COMPAT_LINE_LOG2))
      else $error("decoded size below range");
  end
endmodule

// File: rtl/lz_resv_cmp.sv
module lz_resv_cmp #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] line_base,
  input  logic [ADDR_W-1:0] line_mask,
  input  logic [ADDR_W-1:0] rsv_addr,
  output logic              hit
);
  always_comb begin
    hit = ((rsv_addr & line_mask) == line_base);
  end
endmodule

// File: rtl/lz_store_seq.sv
module lz_store_seq #(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DATA_W        = 64,
  parameter int unsigned MAX_LINE_LOG2 = 7,
  localparam int unsigned LOG_W     = $clog2(MAX_LINE_LOG2 + 1),
  localparam int unsigned BEAT_B    = DATA_W / 8,
  localparam int unsigned BEAT_LOG2 = $clog2(BEAT_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              beat_fire,
  input  logic [ADDR_W-1:0] line_base,
  input  logic [LOG_W-1:0]  size_log2,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              last_beat
);
  logic [MAX_LINE_LOG2-1:0] offset_q;
  logic [MAX_LINE_LOG2:0]   span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
    end else if (load) begin
      offset_q <= '0;
    end else if (beat_fire && !last_beat) begin
      offset_q <= offset_q + MAX_LINE_LOG2'(BEAT_B);
    end
  end

  always_comb begin
    span      = (MAX_LINE_LOG2 + 1)'(1) << size_log2;
    last_beat = ({1'b0, offset_q} == (span - (MAX_LINE_LOG2 + 1)'(BEAT_B)));
    beat_addr = line_base + ADDR_W'(offset_q);
  end

  // Beat addresses remain doubleword aligned (R3)
  p_beat_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |-> (beat_addr[BEAT_LOG2-1:0] == '0));
endmodule

// File: rtl/line_zero_engine.sv
module line_zero_engine #(
  parameter int unsigned ADDR_W           = 32,
  parameter int unsigned DATA_W           = 64,
  parameter int unsigned MIN_LINE_LOG2    = 5,
  parameter int unsigned MAX_LINE_LOG2    = 7,
  parameter int unsigned COMPAT_LINE_LOG2 = 5,
  parameter int unsigned OPC_W            = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        line_sel,
  input  logic              compat_en,
  input  logic [1:0]        compat_mode,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [ADDR_W-1:0] rsv_addr,
  output logic              rsv_kill,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              done
);
  import lz_pkg::*;

  localparam int unsigned LOG_W = $clog2(MAX_LINE_LOG2 + 1);

  lz_phase_e         phase_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] mask_q;
  logic [LOG_W-1:0]  log2_q;
  logic [LOG_W-1:0]  dec_log2;
  logic [ADDR_W-1:0] dec_mask;
  logic              accept;
  logic              beat_fire;
  logic              last_beat;
  logic              resv_hit;

  lz_size_dec #(
    .MIN_LINE_LOG2   (MIN_LINE_LOG2),
    .MAX_LINE_LOG2   (MAX_LINE_LOG2),
    .COMPAT_LINE_LOG2(COMPAT_LINE_LOG2),
    .OPC_W           (OPC_W)
  ) u_size (
    .line_sel   (line_sel),
    .compat_en  (compat_en),
    .compat_mode(compat_mode),
    .opcode     (opcode),
    .size_log2  (dec_log2)
  );

  always_comb begin
    dec_mask    = ~((ADDR_W'(1) << dec_log2) - ADDR_W'(1));
    start_ready = (phase_q == LZ_IDLE);
    accept      = start_valid && start_ready;
    st_valid    = (phase_q == LZ_FILL);
    beat_fire   = st_valid && st_ready;
    done        = (phase_q == LZ_FINISH);
    st_data     = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= LZ_IDLE;
      base_q  <= '0;
      mask_q  <= '0;
      log2_q  <= '0;
    end else begin
      unique case (phase_q)
        LZ_IDLE: if (accept) begin
          phase_q <= LZ_CHECK;
          base_q  <= start_addr & dec_mask;
          mask_q  <= dec_mask;
          log2_q  <= dec_log2;
        end
        LZ_CHECK:  phase_q <= LZ_FILL;
        LZ_FILL:   if (beat_fire && last_beat) phase_q <= LZ_FINISH;
        LZ_FINISH: phase_q <= LZ_IDLE;
        default:   phase_q <= LZ_IDLE;
      endcase
    end
  end

  lz_resv_cmp #(.ADDR_W(ADDR_W)) u_resv (
    .line_base(base_q),
    .line_mask(mask_q),
    .rsv_addr (rsv_addr),
    .hit      (resv_hit)
  );

  assign rsv_kill = (phase_q == LZ_CHECK) && resv_hit;

  lz_store_seq #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .MAX_LINE_LOG2(MAX_LINE_LOG2)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .beat_fire(beat_fire),
    .line_base(base_q),
    .size_log2(log2_q),
    .beat_addr(st_addr),
    .last_beat(last_beat)
  );

  // The reservation check precedes the first store beat (R4)
  p_kill_then_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_kill |=> st_valid);

  // A stalled beat keeps its request and address (R5)
  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_addr)));

  // Completion is a single-cycle strobe followed by idle (R6)
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && start_ready));

  // Nothing is driven while the engine is idle (R7)
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !(st_valid || done || rsv_kill));
endmodule

// File: tb/test_line_zero_engine.sv
module test_line_zero_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] start_addr = '0;
  logic [1:0]  line_sel = '0;
  logic        compat_en = 1'b0;
  logic [1:0]  compat_mode = '0;
  logic [31:0] opcode = '0;
  logic [31:0] rsv_addr = '0;
  logic        rsv_kill;
  logic        st_valid;
  logic        st_ready = 1'b0;
  logic [31:0] st_addr;
  logic [63:0] st_data;
  logic        done;

  always #5 clk = ~clk;

  line_zero_engine i_line_zero_engine (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_addr(start_addr), .line_sel(line_sel),
    .compat_en(compat_en), .compat_mode(compat_mode), .opcode(opcode),
    .rsv_addr(rsv_addr), .rsv_kill(rsv_kill),
    .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .done(done)
  );

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  sel;
    logic        cen;
    logic [31:0] opc;
    logic [1:0]  mode;
    logic [31:0] rsv;
  } cmd_t;

  cmd_t        cmdq[$];
  logic [31:0] exp_q[$];
  int          ph = 0;   // 0 idle, 1 check, 2 fill, 3 done
  bit          exp_hit = 0;
  bit          running = 0;
  int          vectors = 0;
  int          errors = 0;
  int          cycles = 0;

  function automatic int ref_size(cmd_t c);
    if (c.cen && !c.opc[21] && c.mode == 2'd1) return 32;
    case (c.sel)
      2'd0: return 32;
      2'd1: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic cmd_t mk(logic [31:0] a, logic [1:0] s, logic ce, logic [31:0] o,
                              logic [1:0] m, logic [31:0] r);
    cmd_t c;
    c.addr = a; c.sel = s; c.cen = ce; c.opc = o; c.mode = m; c.rsv = r;
    return c;
  endfunction

  always @(negedge clk) begin
    if (running) begin
      cycles++;
      // compare current outputs with the model
      check("R7", "start_ready", 64'(start_ready), 64'(ph == 0));
      check("R4", "rsv_kill", 64'(rsv_kill), 64'(ph == 1 && exp_hit));
      check("R5", "st_valid", 64'(st_valid), 64'(ph == 2));
      check("R6", "done", 64'(done), 64'(ph == 3));
      if (ph == 2 && st_valid) begin
        check("R3", "st_addr", 64'(st_addr), 64'(exp_q[0]));
        check("R3", "st_data", st_data, 64'h0);
      end
      // drive the next cycle
      st_ready = ($urandom % 4) != 0;
      if (ph == 0 && cmdq.size() > 0 && ($urandom % 3) != 0) begin
        start_valid = 1'b1;
        start_addr  = cmdq[0].addr;
        line_sel    = cmdq[0].sel;
        compat_en   = cmdq[0].cen;
        opcode      = cmdq[0].opc;
        compat_mode = cmdq[0].mode;
        rsv_addr    = cmdq[0].rsv;
      end else if (ph != 0) begin
        // R7: offered commands while busy must be ignored
        start_valid = $urandom % 2;
        start_addr  = $urandom;
        line_sel    = 2'($urandom);
      end else begin
        start_valid = 1'b0;
      end
      // advance the model to the next cycle
      case (ph)
        0: if (start_valid) begin
          cmd_t c;
          int sz;
          logic [31:0] msk;
          c   = cmdq.pop_front();
          sz  = ref_size(c);
          msk = ~(32'(sz) - 32'd1);
          exp_hit = ((c.rsv & msk) == (c.addr & msk));
          for (int k = 0; k < sz; k += 8) exp_q.push_back((c.addr & msk) + 32'(k));
          ph = 1;
        end
        1: ph = 2;
        2: if (st_ready) begin
          void'(exp_q.pop_front());
          if (exp_q.size() == 0) ph = 3;
        end
        default: ph = 0;
      endcase
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    // R8: state held in reset
    repeat (2) @(negedge clk);
    check("R8", "start_ready", 64'(start_ready), 64'h1);
    check("R8", "st_valid", 64'(st_valid), 64'h0);
    check("R8", "done", 64'(done), 64'h0);
    check("R8", "rsv_kill", 64'(rsv_kill), 64'h0);
    // R1: every selector, with and without a reservation hit (R4)
    cmdq.push_back(mk(32'h1000_0013, 2'd0, 1'b0, 32'h0, 2'd0, 32'h1000_0000));
    cmdq.push_back(mk(32'h2000_0047, 2'd1, 1'b0, 32'h0, 2'd0, 32'h2000_007C));
    cmdq.push_back(mk(32'h3000_00FF, 2'd2, 1'b0, 32'h0, 2'd0, 32'h3000_0100));
    cmdq.push_back(mk(32'h4000_0085, 2'd3, 1'b0, 32'h0, 2'd0, 32'h0000_0000));
    // R2: override applies, then each condition broken in turn
    cmdq.push_back(mk(32'h5000_0069, 2'd2, 1'b1, 32'h0000_0000, 2'd1, 32'h5000_0040));
    cmdq.push_back(mk(32'h5000_0069, 2'd2, 1'b1, 32'h0020_0000, 2'd1, 32'h5000_0040));
    cmdq.push_back(mk(32'h5000_0069, 2'd2, 1'b1, 32'h0000_0000, 2'd2, 32'h5000_0040));
    cmdq.push_back(mk(32'h5000_0069, 2'd2, 1'b0, 32'h0000_0000, 2'd1, 32'h5000_0040));
    // R3: top of the address space
    cmdq.push_back(mk(32'hFFFF_FFF9, 2'd2, 1'b0, 32'h0, 2'd0, 32'hFFFF_FFFF));
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      a = $urandom;
      cmdq.push_back(mk(a, 2'($urandom), 1'($urandom), $urandom, 2'($urandom),
                        ($urandom % 2) ? (a ^ 32'($urandom % 256)) : $urandom));
    end
    @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    while (cmdq.size() > 0 || ph != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule